// File: doc/BRIEF.md
# Byte-Parity Protected SRAM

This block puts a single-port synchronous RAM behind a simple request interface and protects every byte lane with its own parity bit. Each stored word holds 32 data bits and 4 parity bits. A write stores data and freshly computed parity only in the byte lanes that the access covers. A read returns the whole word one cycle later and checks the stored parity of the covered lanes. A mismatch raises a non-maskable interrupt request and sets a sticky error flag. When a lock bit has been set, the mismatch also drives a break output meant for timer break inputs.

Requests are single-cycle: one read or one write per cycle, with byte, halfword or word size and a byte address. Write data arrives already placed in its byte lanes. Parity checking can be switched off with a level input. The RAM array is not reset. Its power-up content is a parameter, and by default that content carries wrong parity. A read of any lane that was never written therefore reports an error, which matches the behaviour of real uninitialised memory.

Top module: `par_sram_guard`

## Requirements
- R1: A read request (req_valid=1, req_write=0) makes rd_valid high for exactly the next cycle, with rd_data holding the full stored word (all four lanes) of word index req_addr[AW-1:2], whatever the access size.
- R2: A write changes only the lanes that its size and address select. Byte (req_size=0) selects lane req_addr[1:0]. Halfword (req_size=1) selects lanes 1:0 when req_addr[1]=0 and lanes 3:2 when req_addr[1]=1. Word (req_size=2 or 3) selects all four lanes. The data and parity of the other lanes keep their old values. Lane n carries bits 8n+7:8n of req_wdata.
- R3: Parity is even per lane: the stored bit makes the number of ones in byte plus parity even. On a read, only the lanes that the access selects (same rule as R2) are compared with their stored parity.
- R4: A parity mismatch on a read drives nmi_req high for one cycle, two cycles after the request (one cycle after rd_valid). In that same cycle err_flag becomes 1, and it stays 1.
- R5: err_clr=1 clears err_flag at the next clock edge. If a new mismatch is registered at the same edge, the flag stays set.
- R6: While chk_en is 0 at the time of the read request, that read raises no nmi_req, no brk_out and no flag.
- R7: lock_set=1 sets lock_on, which stays 1 until reset. brk_out pulses together with nmi_req only while lock_on is 1.
- R8: After reset, rd_valid, nmi_req, brk_out, err_flag and lock_on are 0. Lanes that have never been written hold the power-up pattern (data 0, parity 1), so a check of such a lane reports an error.
- R9: A write request produces no rd_valid and no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | AW (10) | Byte address |
| req_wdata | input | 32 | Lane-aligned write data |
| rd_data | output | 32 | Read word, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| chk_en | input | 1 | Parity checking enable |
| lock_set | input | 1 | Sets the break routing lock |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky parity error flag |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| brk_out | output | 1 | Timer break pulse |
| lock_on | output | 1 | Lock state |

## Verification
Read data and rd_valid are due one cycle after a read request. The error pulses (nmi_req, brk_out) and the flag update are due one cycle after that. The scoreboard pops an expected entry from its queue at the falling edge where rd_valid shows, and compares the error outputs of that entry at the next falling edge. In every cycle with no pending entry, it treats any error pulse as a failure. Flag clear and the clear-versus-set race are driven so that the clear is high exactly at the edge where the error registers.

// File: rtl/par_sram_pkg.sv
package par_sram_pkg;
  localparam int LANE_W = 8;
  localparam int CELL_W = LANE_W + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic logic even_bit(input logic [LANE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/psg_lane_decode.sv
module psg_lane_decode #(
  parameter int LANES = 4,
  localparam int LB = $clog2(LANES)
) (
  input  logic [LB-1:0]    offs,
  input  logic [1:0]       size,
  output logic [LANES-1:0] mask
);
  int unsigned span;
  int unsigned base;

  always_comb begin
    if (int'(size) >= LB) span = LANES;
    else                  span = 1 << size;
    base = int'(offs) & ~(span - 1);
    mask = (LANES'((1 << span) - 1)) << base;
  end
endmodule

// File: rtl/psg_store.sv
module psg_store
  import par_sram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 256,
  parameter logic [CELL_W-1:0] INIT_CELL = 9'h100,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic [LANES-1:0]              we,
  input  logic                          re,
  input  logic [IW-1:0]                 idx,
  input  logic [LANES*LANE_W-1:0]       wdata,
  output logic [LANES-1:0][CELL_W-1:0]  q
);
  logic [LANES-1:0][CELL_W-1:0] mem [DEPTH];
  logic [LANES-1:0][CELL_W-1:0] wcell;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {LANES{INIT_CELL}};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cell
    assign wcell[l] = {even_bit(wdata[l*LANE_W +: LANE_W]), wdata[l*LANE_W +: LANE_W]};
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[idx][l] <= wcell[l];
    end
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/psg_parity_mon.sv
module psg_parity_mon
  import par_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0][CELL_W-1:0]  q,
  input  logic [LANES-1:0]              mask_q,
  input  logic                          chk_q,
  input  logic                          lock_set,
  input  logic                          err_clr,
  output logic                          nmi_req,
  output logic                          brk_out,
  output logic                          err_flag,
  output logic                          lock_on
);
  logic [LANES-1:0] lane_bad;
  logic             hit;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assign lane_bad[l] = (^q[l]) & mask_q[l];
  end

  assign hit = chk_q & (|lane_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req  <= 1'b0;
      brk_out  <= 1'b0;
      err_flag <= 1'b0;
      lock_on  <= 1'b0;
    end else begin
      nmi_req  <= hit;
      brk_out  <= hit & lock_on;
      err_flag <= hit | (err_flag & ~err_clr);
      lock_on  <= lock_on | lock_set;
    end
  end

  AST_BRK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst) brk_out |-> lock_on); // R7
  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst) lock_on |=> lock_on); // R7
  AST_BRK_WITH_NMI: assert property (@(posedge clk) disable iff (rst) brk_out |-> nmi_req); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst) (err_flag && !err_clr) |=> err_flag); // R5
  AST_NMI_FLAGS: assert property (@(posedge clk) disable iff (rst) nmi_req |-> err_flag); // R4
  AST_NMI_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst) nmi_req |-> $past(chk_q)); // R4
endmodule

// File: rtl/par_sram_guard.sv
module par_sram_guard
  import par_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DATA_W = 32,
  parameter logic [8:0] INIT_CELL = 9'h100,
  localparam int LANES = DATA_W / LANE_W,
  localparam int LB = $clog2(LANES),
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + LB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              chk_en,
  input  logic              lock_set,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              nmi_req,
  output logic              brk_out,
  output logic              lock_on
);
  logic [LANES-1:0]             mask;
  logic [LANES-1:0]             mask_q;
  logic [LANES-1:0]             we;
  logic                         re;
  logic                         chk_q;
  logic [LANES-1:0][CELL_W-1:0] q;

  psg_lane_decode #(.LANES(LANES)) u_dec (
    .offs (req_addr[LB-1:0]),
    .size (req_size),
    .mask (mask)
  );

  assign we = mask & {LANES{req_valid & req_write}};
  assign re = req_valid & ~req_write;

  psg_store #(.LANES(LANES), .DEPTH(DEPTH), .INIT_CELL(INIT_CELL)) u_store (
    .clk   (clk),
    .we    (we),
    .re    (re),
    .idx   (req_addr[AW-1:LB]),
    .wdata (req_wdata),
    .q     (q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      chk_q    <= 1'b0;
      mask_q   <= '0;
    end else begin
      rd_valid <= re;
      chk_q    <= re & chk_en;
      mask_q   <= mask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rd_data[l*LANE_W +: LANE_W] = q[l][LANE_W-1:0];
  end

  psg_parity_mon #(.LANES(LANES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .q        (q),
    .mask_q   (mask_q),
    .chk_q    (chk_q),
    .lock_set (lock_set),
    .err_clr  (err_clr),
    .nmi_req  (nmi_req),
    .brk_out  (brk_out),
    .err_flag (err_flag),
    .lock_on  (lock_on)
  );

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (rst) (req_valid && !req_write) |=> rd_valid); // R1
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_write) |=> !rd_valid); // R9
  AST_CHECK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) (req_valid && !req_write && !chk_en) |-> ##2 !nmi_req); // R6
endmodule

// File: tb/par_sram_guard_bench.sv
module par_sram_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, err_flag, nmi_req, brk_out, lock_on;
  logic        chk_en = 1'b1, lock_set = 1'b0, err_clr = 1'b0;

  par_sram_guard u_par_sram_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .chk_en(chk_en),
    .lock_set(lock_set), .err_clr(err_clr), .err_flag(err_flag),
    .nmi_req(nmi_req), .brk_out(brk_out), .lock_on(lock_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] data;
    bit          err;
    bit          brk;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  exp_t  mon_e;
  int    total = 0, bad = 0;
  bit    lock_m = 0;
  bit    pend = 0, pend_err = 0, pend_brk = 0;
  string pend_tag = "";
  logic [7:0] m_dat [DEPTH][4];
  bit         m_ok  [DEPTH][4];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] bmask(input int a, input int sz);
    if (sz == 0) return 4'b0001 << (a % 4);
    if (sz == 1) return ((a % 4) >= 2) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        check({pend_tag, " R4 nmi_req"}, {31'd0, nmi_req}, {31'd0, pend_err});
        check({pend_tag, " R7 brk_out"}, {31'd0, brk_out}, {31'd0, pend_brk});
      end else if (nmi_req || brk_out) begin
        check("R6 R9 unexpected error pulse", {30'd0, nmi_req, brk_out}, 32'd0);
      end
      pend = 0;
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected rd_valid", 32'd1, 32'd0);
        end else begin
          mon_e = exp_q.pop_front();
          check({mon_e.tag, " R1 rd_data"}, rd_data, mon_e.data);
          pend = 1;
          pend_err = mon_e.err;
          pend_brk = mon_e.brk;
          pend_tag = mon_e.tag;
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int sz, input logic [31:0] d);
    logic [3:0] m;
    m = bmask(a, sz);
    for (int l = 0; l < 4; l++) begin
      if (m[l]) begin
        m_dat[a/4][l] = d[l*8 +: 8];
        m_ok[a/4][l]  = 1;
      end
    end
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_size = 2'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    check("R9 write gives no rd_valid", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic do_read(input int a, input int sz, input string tag);
    exp_t e;
    logic [3:0] m, okv;
    int i;
    i = a / 4;
    m = bmask(a, sz);
    okv = {m_ok[i][3], m_ok[i][2], m_ok[i][1], m_ok[i][0]};
    e.data = {m_dat[i][3], m_dat[i][2], m_dat[i][1], m_dat[i][0]};
    e.err  = chk_en && ((m & ~okv) != 4'b0);
    e.brk  = e.err && lock_m;
    e.tag  = tag;
    exp_q.push_back(e);
    req_valid = 1; req_write = 0; req_addr = AW'(a); req_size = 2'(sz);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic clear_flag();
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++;
    bad++;
    $display("FAIL watchdog R1 act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++)
      for (int l = 0; l < 4; l++) begin
        m_dat[i][l] = 8'h00;
        m_ok[i][l]  = 0;
      end
    idle(3);
    rst = 0;
    // R8 reset state
    check("R8 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R8 nmi_req", {31'd0, nmi_req}, 32'd0);
    check("R8 brk_out", {31'd0, brk_out}, 32'd0);
    check("R8 err_flag", {31'd0, err_flag}, 32'd0);
    check("R8 lock_on", {31'd0, lock_on}, 32'd0);
    idle(1);

    // R1 R3 word write and read back, varied bit counts per byte
    do_write(32'h10, 2, 32'hA1B2C3D4);
    do_read(32'h10, 2, "R1 R3 word");
    do_write(32'h14, 2, 32'h01FF7F80);
    do_read(32'h14, 2, "R3 mixed parity");
    do_read(32'h10, 0, "R3 byte of word");
    idle(3);
    check("R3 no flag on good data", {31'd0, err_flag}, 32'd0);

    // R3 only selected lanes are checked
    do_write(32'h21, 0, 32'h00005A00);
    do_read(32'h21, 0, "R3 written byte only");
    idle(3);
    check("R3 lane-only check no flag", {31'd0, err_flag}, 32'd0);
    do_read(32'h20, 2, "R8 word with unwritten lanes");
    idle(2);
    check("R4 flag set", {31'd0, err_flag}, 32'd1);
    idle(3);
    check("R4 flag sticky", {31'd0, err_flag}, 32'd1);
    clear_flag();
    check("R5 flag cleared", {31'd0, err_flag}, 32'd0);

    // R2 partial writes keep other lanes
    do_write(32'h30, 2, 32'h11223344);
    do_write(32'h32, 1, 32'hBEEF0000);
    do_write(32'h30, 0, 32'h00000099);
    do_read(32'h30, 2, "R2 merged word");
    do_write(32'h41, 1, 32'h0000CAFE);
    do_read(32'h40, 1, "R2 halfword low lanes");
    do_read(32'h42, 1, "R8 halfword high unwritten");
    idle(3);
    check("R4 flag after half read", {31'd0, err_flag}, 32'd1);
    clear_flag();

    // R8 every unwritten lane flags on a byte read, back to back
    for (int l = 0; l < 4; l++) do_read(32'h60 + l, 0, "R8 unwritten byte lane");
    idle(3);
    clear_flag();

    // R6 checking disabled
    chk_en = 0;
    do_read(32'h50, 2, "R6 check off");
    do_read(32'h54, 0, "R6 check off byte");
    chk_en = 1;
    idle(3);
    check("R6 no flag while off", {31'd0, err_flag}, 32'd0);

    // R5 set wins over clear at the same edge
    do_read(32'h58, 2, "R5 race read");
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    check("R5 set wins over clear", {31'd0, err_flag}, 32'd1);
    clear_flag();
    check("R5 cleared after race", {31'd0, err_flag}, 32'd0);

    // R7 lock routing
    lock_set = 1;
    @(negedge clk);
    lock_set = 0;
    lock_m = 1;
    check("R7 lock_on set", {31'd0, lock_on}, 32'd1);
    do_read(32'h70, 2, "R7 break read");
    do_read(32'h10, 2, "R7 good read after lock");
    idle(5);
    check("R7 lock persists", {31'd0, lock_on}, 32'd1);
    clear_flag();
    check("R7 lock survives flag clear", {31'd0, lock_on}, 32'd1);

    // R9 consecutive writes raise nothing
    do_write(32'h80, 2, 32'hFFFFFFFF);
    do_write(32'h84, 0, 32'h000000FE);
    idle(3);
    check("R9 no flag from writes", {31'd0, err_flag}, 32'd0);
    check("R1 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule